// File: doc/BRIEF.md
# Multithreaded Fetch Thread Selector

This block chooses, on each cycle in which the front of a multithreaded pipeline asks for one, the hardware thread that the first stage fetches from next. It holds an ordered list of thread IDs and reads a 2-bit status for each thread. A thread may be chosen only when it is running or idle.

Two policies are available. The fixed policy always names thread 0. The round-robin policy walks the ordered list from head to tail and grants the first thread that may be chosen. It then moves that thread to the tail, so the list stays in least-recently-granted order. When the block is built for one thread, the policy input is ignored and that one thread is granted whenever its status allows.

The grant is registered. A pick strobe sampled at one rising edge produces a grant-valid flag and a thread ID on the outputs right after that edge.

Top module: `fetch_thread_selector`

## Requirements
- R1: The status of thread t is carried on `status_i[2t+1:2t]`. The code 2'b00 means running and 2'b01 means idle; both make the thread eligible. The code 2'b10 means blocked and 2'b11 means squashing; neither is eligible.
- R2: With policy 2'b01 (round-robin), the list is scanned from head to tail and the first eligible thread is granted.
- R3: After a round-robin grant, the granted thread moves to the tail of the list and every other thread keeps its relative order.
- R4: With policy 2'b01, if no thread is eligible, `grant_valid_o` is low and the list is not changed.
- R5: With policy 2'b00 (fixed) and more than one thread, thread 0 is granted whatever its status, and the list is not changed.
- R6: When NUM_THREADS is 1, the policy input is ignored. Thread 0 is granted exactly when it is eligible.
- R7: With policy 2'b10 or 2'b11 and more than one thread, no grant is issued and the list is not changed.
- R8: After reset, the list holds thread IDs in ascending order 0..N-1 from head to tail, `grant_valid_o` is low and `grant_tid_o` is 0.
- R9: The list changes only on an edge where `pick_i` is high and a round-robin grant is issued. If `pick_i` is low at an edge, `grant_valid_o` is low after it and `grant_tid_o` keeps its last value.
- R10: The result for the inputs sampled at a rising edge appears on `grant_valid_o` and `grant_tid_o` immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pick_i | input | 1 | Request a selection at this edge |
| policy_i | input | 2 | 00 fixed, 01 round-robin, 10/11 invalid |
| status_i | input | 2*NUM_THREADS | 2-bit status per thread |
| grant_valid_o | output | 1 | A thread was granted for the last pick |
| grant_tid_o | output | TID_W | ID of the granted thread |

## Verification
The round-robin path is first driven with every thread running, which shows a pure rotation. Single threads are then blocked or squashed, which separates a head-first scan from a pointer rotation, because the list order after a skip is different. Blocks where no thread is eligible, fixed-policy picks on a squashing thread 0, invalid policy codes and idle strobes follow. Each is followed by round-robin picks, which read the list order back through the grants and show that these cases leave the list alone. A long seeded random mix of the same inputs and a one-thread build cover the remaining combinations.

// File: rtl/fts_pkg.sv
package fts_pkg;

    typedef enum logic [1:0] {
        TS_RUNNING   = 2'b00,
        TS_IDLE      = 2'b01,
        TS_BLOCKED   = 2'b10,
        TS_SQUASHING = 2'b11
    } thread_state_e;

    typedef enum logic [1:0] {
        POL_FIXED0 = 2'b00,
        POL_RROBIN = 2'b01,
        POL_RSVD2  = 2'b10,
        POL_RSVD3  = 2'b11
    } pick_policy_e;

    // Running and idle threads may be fetched from
    function automatic logic state_can_fetch(input logic [1:0] st);
        return (st == TS_RUNNING) || (st == TS_IDLE);
    endfunction

endpackage

// File: rtl/fts_elig.sv
module fts_elig
    import fts_pkg::*;
#(
    parameter int NUM_THREADS = 4
) (
    input  logic [2*NUM_THREADS-1:0] status_i,
    output logic [NUM_THREADS-1:0]   elig_o
);

    for (genvar t = 0; t < NUM_THREADS; t++) begin : g_thr
        assign elig_o[t] = state_can_fetch(status_i[2*t +: 2]);
    end

endmodule

// File: rtl/fts_scan.sv
module fts_scan #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic [NUM_THREADS-1:0][TID_W-1:0] order_i,
    input  logic [NUM_THREADS-1:0]            elig_i,
    output logic                              hit_o,
    output logic [TID_W-1:0]                  pos_o,
    output logic [TID_W-1:0]                  tid_o
);

    // Walk from tail to head so the lowest matching slot is written last
    always_comb begin
        hit_o = 1'b0;
        pos_o = '0;
        for (int i = NUM_THREADS - 1; i >= 0; i--) begin
            if (elig_i[order_i[i]]) begin
                hit_o = 1'b1;
                pos_o = TID_W'(i);
            end
        end
        tid_o = order_i[pos_o];
    end

endmodule

// File: rtl/fts_list.sv
module fts_list #(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              rotate_i,
    input  logic [TID_W-1:0]                  pos_i,
    output logic [NUM_THREADS-1:0][TID_W-1:0] order_o
);

    typedef struct packed {
        logic [NUM_THREADS-1:0][TID_W-1:0] order;
    } list_st_t;

    list_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rotate_i) begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                if (i >= int'(pos_i)) begin
                    if (i == NUM_THREADS - 1) begin
                        st_d.order[i] = st_q.order[pos_i];
                    end else begin
                        st_d.order[i] = st_q.order[(i + 1) % NUM_THREADS];
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_THREADS; i++) begin
                st_q.order[i] <= TID_W'(i);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign order_o = st_q.order;

endmodule

// File: rtl/fetch_thread_selector.sv
module fetch_thread_selector
    import fts_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = (NUM_THREADS > 1) ? $clog2(NUM_THREADS) : 1
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     pick_i,
    input  logic [1:0]               policy_i,
    input  logic [2*NUM_THREADS-1:0] status_i,
    output logic                     grant_valid_o,
    output logic [TID_W-1:0]         grant_tid_o
);

    typedef struct packed {
        logic             vld;
        logic [TID_W-1:0] tid;
    } grant_st_t;

    logic [NUM_THREADS-1:0]            elig;
    logic [NUM_THREADS-1:0][TID_W-1:0] order;
    logic                              scan_hit;
    logic [TID_W-1:0]                  scan_pos;
    logic [TID_W-1:0]                  scan_tid;
    logic                              grant_now;
    logic [TID_W-1:0]                  tid_now;
    logic                              rotate;
    grant_st_t                         gr_d, gr_q;

    fts_elig #(.NUM_THREADS(NUM_THREADS)) u_elig (
        .status_i (status_i),
        .elig_o   (elig)
    );

    fts_scan #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_scan (
        .order_i (order),
        .elig_i  (elig),
        .hit_o   (scan_hit),
        .pos_o   (scan_pos),
        .tid_o   (scan_tid)
    );

    fts_list #(.NUM_THREADS(NUM_THREADS), .TID_W(TID_W)) u_list (
        .clk      (clk),
        .rst_n    (rst_n),
        .rotate_i (rotate),
        .pos_i    (scan_pos),
        .order_o  (order)
    );

    if (NUM_THREADS == 1) begin : g_one
        // Policy plays no part with a single thread
        always_comb begin
            grant_now = pick_i & elig[0];
            tid_now   = '0;
            rotate    = 1'b0;
        end
    end else begin : g_multi
        always_comb begin
            grant_now = 1'b0;
            tid_now   = '0;
            rotate    = 1'b0;
            if (pick_i) begin
                unique case (pick_policy_e'(policy_i))
                    POL_FIXED0: begin
                        grant_now = 1'b1;
                        tid_now   = '0;
                    end
                    POL_RROBIN: begin
                        grant_now = scan_hit;
                        tid_now   = scan_tid;
                        rotate    = scan_hit;
                    end
                    default: begin
                        grant_now = 1'b0;
                    end
                endcase
            end
        end
    end

    always_comb begin
        gr_d     = gr_q;
        gr_d.vld = grant_now;
        if (grant_now) begin
            gr_d.tid = tid_now;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gr_q <= '0;
        end else begin
            gr_q <= gr_d;
        end
    end

    assign grant_valid_o = gr_q.vld;
    assign grant_tid_o   = gr_q.tid;

endmodule

// File: rtl/fts_checker.sv
module fts_checker
    import fts_pkg::*;
#(
    parameter int NUM_THREADS = 4,
    parameter int TID_W       = 2
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     pick_i,
    input logic [1:0]               policy_i,
    input logic [2*NUM_THREADS-1:0] status_i,
    input logic                     grant_valid_o,
    input logic [TID_W-1:0]         grant_tid_o
);

    logic                     pick_q;
    logic [1:0]               pol_q;
    logic [2*NUM_THREADS-1:0] stat_q;
    logic                     any_elig_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pick_q     <= 1'b0;
            pol_q      <= 2'b00;
            stat_q     <= '0;
            any_elig_q <= 1'b0;
        end else begin
            pick_q     <= pick_i;
            pol_q      <= policy_i;
            stat_q     <= status_i;
            any_elig_q <= 1'b0;
            for (int t = 0; t < NUM_THREADS; t++) begin
                if (state_can_fetch(status_i[2*t +: 2])) any_elig_q <= 1'b1;
            end
        end
    end

    localparam bit MULTI = (NUM_THREADS > 1);

    // R1
    rr_grant_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_valid_o && pick_q && (pol_q == 2'b01 || !MULTI))
        |-> state_can_fetch(stat_q[2*grant_tid_o +: 2]));

    // R4
    rr_any_elig_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pick_q && (pol_q == 2'b01 || !MULTI)) |-> (grant_valid_o == any_elig_q));

    // R5
    fixed_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (MULTI && pick_q && pol_q == 2'b00) |-> (grant_valid_o && grant_tid_o == '0));

    // R7
    bad_policy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (MULTI && pick_q && pol_q[1]) |-> !grant_valid_o);

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !pick_i |=> (!grant_valid_o && $stable(grant_tid_o)));

    // R10
    tid_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid_o |-> (int'(grant_tid_o) < NUM_THREADS));

endmodule

bind fetch_thread_selector fts_checker #(
    .NUM_THREADS (NUM_THREADS),
    .TID_W       (TID_W)
) u_fts_chk (.*);

// File: tb/tb_fetch_thread_selector.sv
module tb_fetch_thread_selector;

    localparam int N  = 4;
    localparam int TW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          pick = 1'b0;
    logic [1:0]    pol = 2'b00;
    logic [2*N-1:0] stat = '0;
    logic          gv;
    logic [TW-1:0] gt;

    logic          pick1 = 1'b0;
    logic [1:0]    pol1 = 2'b00;
    logic [1:0]    stat1 = 2'b00;
    logic          gv1;
    logic          gt1;

    int checks = 0;
    int fails  = 0;

    int model_list [N];
    int model_tid;
    int    q_vld [$];
    int    q_tid [$];
    string q_req [$];

    always #10 clk = ~clk;

    fetch_thread_selector #(.NUM_THREADS(N)) dut (
        .clk(clk), .rst_n(rst_n), .pick_i(pick), .policy_i(pol),
        .status_i(stat), .grant_valid_o(gv), .grant_tid_o(gt)
    );

    fetch_thread_selector #(.NUM_THREADS(1)) dut_one (
        .clk(clk), .rst_n(rst_n), .pick_i(pick1), .policy_i(pol1),
        .status_i(stat1), .grant_valid_o(gv1), .grant_tid_o(gt1)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic bit can_go(input logic [1:0] s);
        return s == 2'b00 || s == 2'b01;
    endfunction

    // Driver: set inputs at the falling edge and queue the expected result
    task automatic step(input bit p, input logic [1:0] pl, input logic [2*N-1:0] st, input string req);
        int ev;
        @(negedge clk);
        pick = p; pol = pl; stat = st;
        ev = 0;
        if (p) begin
            if (pl == 2'b00) begin
                ev = 1; model_tid = 0;
            end else if (pl == 2'b01) begin
                for (int k = 0; k < N; k++) begin
                    if (ev == 0 && can_go(st[2*model_list[k] +: 2])) begin
                        int g;
                        ev = 1;
                        g = model_list[k];
                        model_tid = g;
                        for (int j = k; j < N - 1; j++) model_list[j] = model_list[j+1];
                        model_list[N-1] = g;
                    end
                end
            end
        end
        q_vld.push_back(ev);
        q_tid.push_back(model_tid);
        q_req.push_back(req);
    endtask

    // Monitor: compare just after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q_vld.size() > 0) begin
                int ev, et;
                string r;
                ev = q_vld.pop_front();
                et = q_tid.pop_front();
                r  = q_req.pop_front();
                check({r, " valid"}, int'(gv), ev);
                check({r, " tid"}, int'(gt), et);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        for (int i = 0; i < N; i++) model_list[i] = i;
        model_tid = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R8 reset state
        check("R8 reset valid", int'(gv), 0);
        check("R8 reset tid", int'(gt), 0);
        check("R8 reset valid one", int'(gv1), 0);

        // R2 R3 R10: all running, pure rotation from ascending order
        for (int i = 0; i < 4; i++) step(1, 2'b01, 8'h00, "R2 R10 all running");
        // R1 thread 0 blocked, others running and idle
        step(1, 2'b01, 8'b01_00_01_10, "R1 skip blocked");
        step(1, 2'b01, 8'b01_00_01_10, "R3 order after skip");
        step(1, 2'b01, 8'b01_00_01_10, "R3 order after skip");
        // R4 none eligible
        step(1, 2'b01, 8'b11_10_11_10, "R4 none eligible");
        step(1, 2'b01, 8'h00, "R4 list unchanged");
        // R5 fixed policy, thread 0 squashing
        step(1, 2'b00, 8'b00_00_00_11, "R5 fixed ignores status");
        step(1, 2'b01, 8'h00, "R5 list unchanged");
        // R7 invalid codes
        step(1, 2'b10, 8'h00, "R7 policy 10");
        step(1, 2'b11, 8'h00, "R7 policy 11");
        step(1, 2'b01, 8'h00, "R7 list unchanged");
        // R9 strobe low
        step(0, 2'b01, 8'h00, "R9 no pick");
        step(0, 2'b00, 8'h00, "R9 no pick");
        step(1, 2'b01, 8'h00, "R9 list unchanged");
        // R1 only one idle thread
        step(1, 2'b01, 8'b10_01_11_10, "R1 idle eligible");
        step(1, 2'b01, 8'b10_01_11_10, "R1 idle eligible again");
        // seeded random mix
        void'($urandom(7));
        for (int i = 0; i < 300; i++) begin
            logic [1:0] rp;
            rp = ($urandom_range(0, 9) < 7) ? 2'b01 : 2'($urandom_range(0, 3));
            step(($urandom_range(0, 3) != 0), rp, 8'($urandom()), "R2 R3 random mix");
        end
        step(0, 2'b01, 8'h00, "R9 drain");
        repeat (3) @(posedge clk);

        // R6 single-thread build: policy ignored
        @(negedge clk); pick1 = 1; pol1 = 2'b11; stat1 = 2'b00;
        @(negedge clk); check("R6 invalid policy ignored", int'(gv1), 1);
        check("R6 tid", int'(gt1), 0);
        pol1 = 2'b00; stat1 = 2'b10;
        @(negedge clk); check("R6 blocked no grant", int'(gv1), 0);
        pol1 = 2'b01; stat1 = 2'b01;
        @(negedge clk); check("R6 idle granted", int'(gv1), 1);
        stat1 = 2'b11;
        @(negedge clk); check("R6 squashing no grant", int'(gv1), 0);
        pick1 = 0; stat1 = 2'b00;
        @(negedge clk); check("R9 one no pick", int'(gv1), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule